// File: doc/BRIEF.md
# Byte-Lane Dual-Port Memory with Contention Flag

This block is a synchronous memory that two ports share. Each port has its own address, write data, read data and control group, and the two ports can read or write any word in the same clock cycle. Every port has six active-low controls: enable, read/write direction, output gate, upper-lane select, lower-lane select and flag-space select. A decoder turns these controls into a write-lane mask, a read-lane mask and a per-lane output-enable vector. The decoder drives the output-enable vector in place of bidirectional pins.

The word is two 8-bit lanes. The array depth is `2**ADDR_W` words, so `ADDR_W = 14` gives the full 16384-word configuration. The default is smaller so that elaboration stays light. Read data and the output-enable vector are registered, and they appear one cycle after the request.

A mode input selects the contention scheme. In leader mode, the block compares the two addresses itself. When both ports are selected on one address, it raises a busy flag to the right port, and that port's write is dropped. In follower mode, busy flags arrive from outside, and each one blocks the write of its own port.

Top module: `dpr_byte_ram`

## Requirements
- R1: Storage holds `2**ADDR_W` words of 16 bits per port address. A word that one port writes is returned by a later read from either port.
- R2: When a port's enable is high, that port writes nothing. In the next cycle its output-enable vector is 00 and its read data is 0.
- R3: When both lane selects of a port are high, no lane is written. The next cycle's output-enable vector for that port is 00.
- R4: Lane 1 is data bits 15:8 and is gated by the upper select, which is output-enable bit 1. Lane 0 is bits 7:0 and is gated by the lower select, which is output-enable bit 0. A write changes only the selected lanes. An unselected lane reads as zero.
- R5: A write happens when enable and direction are both low, whatever the output gate is. A write cycle gives an output-enable vector of 00 in the next cycle.
- R6: A read happens when enable and output gate are low and direction is high. The next cycle shows the stored value of the selected lanes and sets their output-enable bits. With the output gate high, the output-enable vector is 00 and the data is 0.
- R7: A low flag-space select blocks all array access for that port: no write, and an output-enable vector of 00.
- R8: In leader mode (`lead_i` = 1), `busy_out_r` is high in the same cycle when both ports are selected (enable low, flag-space select high) on equal addresses. `busy_out_l` stays low. The right port's write is dropped, and its read still returns the stored data.
- R9: In follower mode (`lead_i` = 0), both busy outputs are low. A high `busy_in_l` or `busy_in_r` drops that port's write and leaves its read unchanged.
- R10: A read returns the word as it was before any write made in the same cycle, from either port.
- R11: If both ports write the same lane of one address in the same cycle and neither write is dropped, the left port's data is kept.
- R12: After reset, both output-enable vectors are 00 and both read buses are 0. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_i | input | 1 | 1: internal contention compare, 0: external busy inputs |
| ce_n_l | input | 1 | Left port enable, active low |
| rw_n_l | input | 1 | Left direction, high read, low write |
| oe_n_l | input | 1 | Left output gate, active low |
| ub_n_l | input | 1 | Left upper-lane select, active low |
| lb_n_l | input | 1 | Left lower-lane select, active low |
| sem_n_l | input | 1 | Left flag-space select, low blocks array access |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | 16 | Left write data |
| busy_in_l | input | 1 | Left external busy (follower mode) |
| rdata_l | output | 16 | Left read data, registered |
| oe_lanes_l | output | 2 | Left per-lane output enable, registered |
| busy_out_l | output | 1 | Left busy flag |
| ce_n_r | input | 1 | Right port enable, active low |
| rw_n_r | input | 1 | Right direction |
| oe_n_r | input | 1 | Right output gate, active low |
| ub_n_r | input | 1 | Right upper-lane select, active low |
| lb_n_r | input | 1 | Right lower-lane select, active low |
| sem_n_r | input | 1 | Right flag-space select |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | 16 | Right write data |
| busy_in_r | input | 1 | Right external busy (follower mode) |
| rdata_r | output | 16 | Right read data, registered |
| oe_lanes_r | output | 2 | Right per-lane output enable, registered |
| busy_out_r | output | 1 | Right busy flag |

## Verification
The interesting overlap is between the contention logic and the byte-lane datapath. In one cycle the left port can write a word while the right port reads or writes the same word. The right port's write must then be dropped, or in follower mode the left write must win. Every read must still return the word as it was before the edge. The bench drives such clashes on purpose. It also keeps random addresses in a small window and switches the mode input between runs, so that many clashes occur. It judges each cycle against a bench model that first reads, then applies the surviving writes lane by lane, right port before left.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic             sel;
        logic [LANES-1:0] wr_lanes;
        logic [LANES-1:0] rd_lanes;
    } port_cmd_t;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic             ce_n,
    input  logic             rw_n,
    input  logic             oe_n,
    input  logic             sem_n,
    input  logic [LANES-1:0] lane_n,
    output port_cmd_t        cmd
);
    logic [LANES-1:0] lanes;

    always_comb begin
        lanes        = ~lane_n;
        cmd.sel      = !ce_n && sem_n;
        cmd.wr_lanes = (cmd.sel && !rw_n) ? lanes : '0;
        cmd.rd_lanes = (cmd.sel && rw_n && !oe_n) ? lanes : '0;
    end
endmodule

// File: rtl/dpr_contention.sv
module dpr_contention #(
    parameter int ADDR_W = 10
) (
    input  logic              lead,
    input  logic              sel_l,
    input  logic              sel_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              busy_in_l,
    input  logic              busy_in_r,
    output logic              busy_out_l,
    output logic              busy_out_r,
    output logic              stall_l,
    output logic              stall_r
);
    logic clash;

    always_comb begin
        clash      = lead && sel_l && sel_r && (addr_l == addr_r);
        busy_out_l = 1'b0;
        busy_out_r = clash;
        stall_l    = !lead && busy_in_l;
        stall_r    = lead ? clash : busy_in_r;
    end
endmodule

// File: rtl/dpr_lane_array.sv
module dpr_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_l,
    input  logic              re_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [LANE_W-1:0] wd_l,
    input  logic              we_r,
    input  logic              re_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [LANE_W-1:0] wd_r,
    output logic [LANE_W-1:0] rd_l,
    output logic [LANE_W-1:0] rd_r
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [LANE_W-1:0] rd_l;
        logic [LANE_W-1:0] rd_r;
    } state_t;

    logic [LANE_W-1:0] mem [DEPTH];
    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rd_l = re_l ? mem[addr_l] : '0;
        st_d.rd_r = re_r ? mem[addr_r] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // right first, left last: left keeps a shared lane
    always_ff @(posedge clk) begin
        if (we_r) mem[addr_r] <= wd_r;
        if (we_l) mem[addr_l] <= wd_l;
    end

    assign rd_l = st_q.rd_l;
    assign rd_r = st_q.rd_r;

    a_r11_left_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we_l && we_r && addr_l == addr_r) |=> (mem[$past(addr_l)] == $past(wd_l)));

    a_r6_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !re_l |=> (rd_l == '0));
endmodule

// File: rtl/dpr_byte_ram.sv
module dpr_byte_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_i,
    input  logic              ce_n_l,
    input  logic              rw_n_l,
    input  logic              oe_n_l,
    input  logic              ub_n_l,
    input  logic              lb_n_l,
    input  logic              sem_n_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [15:0]       wdata_l,
    input  logic              busy_in_l,
    output logic [15:0]       rdata_l,
    output logic [1:0]        oe_lanes_l,
    output logic              busy_out_l,
    input  logic              ce_n_r,
    input  logic              rw_n_r,
    input  logic              oe_n_r,
    input  logic              ub_n_r,
    input  logic              lb_n_r,
    input  logic              sem_n_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [15:0]       wdata_r,
    input  logic              busy_in_r,
    output logic [15:0]       rdata_r,
    output logic [1:0]        oe_lanes_r,
    output logic              busy_out_r
);
    typedef struct packed {
        logic [LANES-1:0] oe_l;
        logic [LANES-1:0] oe_r;
    } state_t;

    port_cmd_t cmd_l, cmd_r;
    logic      stall_l, stall_r;
    state_t    st_d, st_q;

    dpr_port_decode u_dec_l (
        .ce_n(ce_n_l), .rw_n(rw_n_l), .oe_n(oe_n_l), .sem_n(sem_n_l),
        .lane_n({ub_n_l, lb_n_l}), .cmd(cmd_l)
    );

    dpr_port_decode u_dec_r (
        .ce_n(ce_n_r), .rw_n(rw_n_r), .oe_n(oe_n_r), .sem_n(sem_n_r),
        .lane_n({ub_n_r, lb_n_r}), .cmd(cmd_r)
    );

    dpr_contention #(.ADDR_W(ADDR_W)) u_cont (
        .lead(lead_i), .sel_l(cmd_l.sel), .sel_r(cmd_r.sel),
        .addr_l(addr_l), .addr_r(addr_r),
        .busy_in_l(busy_in_l), .busy_in_r(busy_in_r),
        .busy_out_l(busy_out_l), .busy_out_r(busy_out_r),
        .stall_l(stall_l), .stall_r(stall_r)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpr_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
            .clk(clk), .rst_n(rst_n),
            .we_l(cmd_l.wr_lanes[g] && !stall_l), .re_l(cmd_l.rd_lanes[g]),
            .addr_l(addr_l), .wd_l(wdata_l[g*LANE_W +: LANE_W]),
            .we_r(cmd_r.wr_lanes[g] && !stall_r), .re_r(cmd_r.rd_lanes[g]),
            .addr_r(addr_r), .wd_r(wdata_r[g*LANE_W +: LANE_W]),
            .rd_l(rdata_l[g*LANE_W +: LANE_W]),
            .rd_r(rdata_r[g*LANE_W +: LANE_W])
        );

        a_r4_unlit_lane_zero_l: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_lanes_l[g] |-> (rdata_l[g*LANE_W +: LANE_W] == '0));
        a_r4_unlit_lane_zero_r: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_lanes_r[g] |-> (rdata_r[g*LANE_W +: LANE_W] == '0));
    end

    always_comb begin
        st_d      = st_q;
        st_d.oe_l = cmd_l.rd_lanes;
        st_d.oe_r = cmd_r.rd_lanes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe_lanes_l = st_q.oe_l;
    assign oe_lanes_r = st_q.oe_r;

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n_l |=> (oe_lanes_l == 2'b00 && rdata_l == 16'h0));
    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n_r && !rw_n_r) |=> (oe_lanes_r == 2'b00));
    a_r7_flag_space_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !sem_n_l |=> (oe_lanes_l == 2'b00));
    a_r8_left_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lead_i |-> !busy_out_l);
    a_r9_follower_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lead_i |-> (!busy_out_l && !busy_out_r));
endmodule

// File: tb/dpr_byte_ram_test.sv
module dpr_byte_ram_test;
    localparam int AW = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, lead;
    logic ce_n[2], rw_n[2], oe_n[2], ub_n[2], lb_n[2], sem_n[2], bin[2];
    logic [AW-1:0] addr[2];
    logic [15:0] wd[2];
    logic [15:0] rd_l, rd_r;
    logic [1:0]  oe_l, oe_r;
    logic        bo_l, bo_r;

    int errs = 0;
    int checks = 0;
    logic [15:0] mdl [16];
    logic [1:0]  e_oe[2];
    logic [15:0] e_rd[2];
    logic        e_bl, e_br;

    dpr_byte_ram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .lead_i(lead),
        .ce_n_l(ce_n[0]), .rw_n_l(rw_n[0]), .oe_n_l(oe_n[0]), .ub_n_l(ub_n[0]),
        .lb_n_l(lb_n[0]), .sem_n_l(sem_n[0]), .addr_l(addr[0]), .wdata_l(wd[0]),
        .busy_in_l(bin[0]), .rdata_l(rd_l), .oe_lanes_l(oe_l), .busy_out_l(bo_l),
        .ce_n_r(ce_n[1]), .rw_n_r(rw_n[1]), .oe_n_r(oe_n[1]), .ub_n_r(ub_n[1]),
        .lb_n_r(lb_n[1]), .sem_n_r(sem_n[1]), .addr_r(addr[1]), .wdata_r(wd[1]),
        .busy_in_r(bin[1]), .rdata_r(rd_r), .oe_lanes_r(oe_r), .busy_out_r(bo_r)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drv(int p, logic c, logic rw, logic o, logic u, logic l,
                       logic s, int a, logic [15:0] d);
        ce_n[p] = c; rw_n[p] = rw; oe_n[p] = o; ub_n[p] = u; lb_n[p] = l;
        sem_n[p] = s; addr[p] = AW'(a); wd[p] = d;
    endtask

    task automatic idle();
        for (int p = 0; p < 2; p++) begin
            drv(p, 1, 1, 1, 1, 1, 1, 0, 16'h0);
            bin[p] = 1'b0;
        end
    endtask

    // reference: reads see the old word, then surviving writes, right before left
    task automatic model_step();
        logic       sel[2];
        logic [1:0] wl[2];
        logic [1:0] rl[2];
        logic       stall[2];
        for (int p = 0; p < 2; p++) begin
            sel[p] = !ce_n[p] && sem_n[p];
            wl[p]  = (sel[p] && !rw_n[p]) ? {!ub_n[p], !lb_n[p]} : 2'b00;
            rl[p]  = (sel[p] && rw_n[p] && !oe_n[p]) ? {!ub_n[p], !lb_n[p]} : 2'b00;
        end
        e_bl = 1'b0;
        e_br = lead && sel[0] && sel[1] && (addr[0] == addr[1]);
        stall[0] = !lead && bin[0];
        stall[1] = lead ? e_br : bin[1];
        for (int p = 0; p < 2; p++) begin
            e_oe[p] = rl[p];
            e_rd[p] = mdl[addr[p][3:0]] & {{8{rl[p][1]}}, {8{rl[p][0]}}};
        end
        for (int p = 1; p >= 0; p--) begin
            if (!stall[p]) begin
                if (wl[p][1]) mdl[addr[p][3:0]][15:8] = wd[p][15:8];
                if (wl[p][0]) mdl[addr[p][3:0]][7:0]  = wd[p][7:0];
            end
        end
    endtask

    task automatic step(string tag);
        model_step();
        #1;
        chk(tag, "busy_out_l", {15'b0, bo_l}, {15'b0, e_bl});
        chk(tag, "busy_out_r", {15'b0, bo_r}, {15'b0, e_br});
        @(posedge clk);
        @(negedge clk);
        chk(tag, "oe_lanes_l", {14'b0, oe_l}, {14'b0, e_oe[0]});
        chk(tag, "oe_lanes_r", {14'b0, oe_r}, {14'b0, e_oe[1]});
        chk(tag, "rdata_l", rd_l, e_rd[0]);
        chk(tag, "rdata_r", rd_r, e_rd[1]);
    endtask

    task automatic rd(int p, int a, string tag);
        idle();
        drv(p, 0, 1, 0, 0, 0, 1, a, 16'h0);
        step(tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        lead  = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: quiet after reset
        chk("R12", "oe_lanes_l", {14'b0, oe_l}, 16'h0);
        chk("R12", "oe_lanes_r", {14'b0, oe_r}, 16'h0);
        chk("R12", "rdata_l", rd_l, 16'h0);
        chk("R12", "rdata_r", rd_r, 16'h0);

        // R1: fill the window and read back from both ports
        for (int a = 0; a < 16; a++) begin
            idle();
            drv(0, 0, 0, 1, 0, 0, 1, a, 16'(a * 16'h1111) ^ 16'h5a3c);
            step("R1");
        end
        idle(); drv(1, 0, 0, 1, 0, 0, 1, 5, 16'hbeef); step("R1");
        rd(0, 5, "R1");
        rd(1, 9, "R1");

        // R2: deselected write attempt
        idle(); drv(0, 1, 0, 0, 0, 0, 1, 2, 16'hdead); step("R2");
        rd(0, 2, "R2");

        // R3: no lane selected
        idle(); drv(1, 0, 0, 0, 1, 1, 1, 3, 16'h1234); step("R3");
        idle(); drv(1, 0, 1, 0, 1, 1, 1, 3, 16'h0); step("R3");
        rd(1, 3, "R3");

        // R4: lane gating
        idle(); drv(0, 0, 0, 1, 0, 1, 1, 4, 16'hab00); step("R4");
        idle(); drv(0, 0, 1, 0, 1, 0, 1, 4, 16'h0); step("R4");
        idle(); drv(0, 0, 1, 0, 0, 1, 1, 4, 16'h0); step("R4");
        idle(); drv(1, 0, 0, 1, 1, 0, 1, 4, 16'h00cd); step("R4");
        rd(1, 4, "R4");

        // R5: write with output gate low
        idle(); drv(0, 0, 0, 0, 0, 0, 1, 6, 16'h6006); step("R5");
        rd(0, 6, "R5");

        // R6: output gate high
        idle(); drv(1, 0, 1, 1, 0, 0, 1, 6, 16'h0); step("R6");

        // R7: flag space blocks write and read
        idle(); drv(0, 0, 0, 0, 0, 0, 0, 7, 16'h7777); step("R7");
        idle(); drv(0, 0, 1, 0, 0, 0, 0, 7, 16'h0); step("R7");
        rd(0, 7, "R7");

        // R8: leader-mode clashes
        lead = 1'b1;
        idle(); drv(0, 0, 0, 1, 0, 0, 1, 8, 16'h1111);
        drv(1, 0, 0, 1, 0, 0, 1, 8, 16'h2222); step("R8");
        rd(1, 8, "R8");
        idle(); drv(0, 0, 0, 1, 0, 0, 1, 8, 16'h3333);
        drv(1, 0, 1, 0, 0, 0, 1, 8, 16'h0); step("R8");
        idle(); drv(0, 0, 1, 0, 0, 0, 1, 9, 16'h0);
        drv(1, 0, 0, 1, 0, 0, 1, 9, 16'h4444); step("R8");
        rd(0, 9, "R8");

        // R9: follower mode with external busy
        lead = 1'b0;
        idle(); drv(1, 0, 0, 1, 0, 0, 1, 10, 16'haaaa); bin[1] = 1'b1; step("R9");
        idle(); drv(0, 0, 0, 1, 0, 0, 1, 11, 16'hbbbb); bin[0] = 1'b1; step("R9");
        idle(); drv(0, 0, 1, 0, 0, 0, 1, 10, 16'h0); bin[0] = 1'b1; step("R9");
        rd(1, 11, "R9");

        // R10: read sees the word from before a same-cycle write
        idle(); drv(0, 0, 0, 1, 0, 0, 1, 12, 16'hc0de);
        drv(1, 0, 1, 0, 0, 0, 1, 12, 16'h0); step("R10");
        rd(1, 12, "R10");

        // R11: follower mode, both ports write one word
        idle(); drv(0, 0, 0, 1, 0, 0, 1, 13, 16'h1357);
        drv(1, 0, 0, 1, 0, 1, 1, 13, 16'h2468); step("R11");
        rd(0, 13, "R11");

        // R6: random traffic in a small address window
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) lead = $urandom % 2;
            for (int p = 0; p < 2; p++) begin
                drv(p, ($urandom % 5) == 0, $urandom % 2, ($urandom % 4) == 0,
                    ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 8) != 0,
                    $urandom % 6, 16'($urandom));
                bin[p] = ($urandom % 4) == 0;
            end
            step("R6");
        end

        summary();
        $finish;
    end
endmodule